// File: doc/BRIEF.md
# Two-Cell Receive Buffer with Byte and Cell Handshake

This block is the receive end of an 8-bit cell interface between a line-side datapath and a link-layer device such as a segmentation and reassembly engine. Bytes from the receive datapath arrive one per `in_valid` strobe. An internal cell writer counts them into fixed 53-byte cells and places them into storage that holds two whole cells. A cell counts as complete, and becomes readable, on the clock that accepts its 53rd byte.

The link-layer device pulls bytes out by raising `rd_en`. The block always presents the byte at the head of the buffer on `rd_data`, so a byte is taken on the clock edge where `rd_en` is high and data is present. Three status outputs guide the reader. `rd_soc` marks the first byte of a cell. `rd_empty` shows that no readable byte is left. `rd_clav` shows that a whole complete cell is waiting with none of its bytes read yet.

When a new cell begins and both slots are taken, the whole cell is discarded and `ovf_pulse` reports it. A slot counts as taken while its cell is being read out. The reset input is asynchronous and active low. It is released inside the block through a two-stage synchronizer.

Top module: `cell_rx_port`

## Requirements
- R1: A byte leaves the buffer only on a rising clock edge where `rd_en` is 1 and `rd_empty` is 0. The byte taken is the value on `rd_data` just before that edge. With `rd_en` and `in_valid` both low, `rd_data`, `rd_soc` and `rd_empty` hold their values.
- R2: `rd_soc` is 1 exactly when `rd_empty` is 0 and `rd_data` carries byte 0 of a 53-byte cell.
- R3: `rd_empty` is 1 when no complete cell has unread bytes. Bytes of a cell still being written are never readable.
- R4: `rd_clav` is 1 when at least one complete cell is held with none of its bytes read. A partly written cell never sets it.
- R5: Up to two complete cells are held. Bytes come out in the order they were written, across cell boundaries.
- R6: Suppose the first byte of a new cell arrives while two complete cells are held, counting a cell that is partly read. Then all 53 bytes of that cell are discarded. `ovf_pulse` is 1 for exactly one cycle, on the cycle after that first byte was accepted.
- R7: A read attempted while `rd_empty` is 1 is ignored. The next cell to arrive is read from its byte 0, with `rd_soc` set.
- R8: Two events may fall on the same clock edge: the 53rd byte of an incoming cell is accepted, and the last byte of another cell is read. In that case one cell is still held. A further incoming cell is then accepted without overflow.
- R9: During and right after reset, `rd_empty` is 1 and `rd_clav`, `rd_soc` and `ovf_pulse` are 0. Any cell held before reset is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming byte strobe from the receive datapath |
| in_byte | input | 8 | Incoming byte |
| rd_en | input | 1 | Read strobe from the link-layer device |
| rd_data | output | 8 | Byte at the head of the buffer |
| rd_soc | output | 1 | Head byte is byte 0 of a cell |
| rd_empty | output | 1 | No readable byte present |
| rd_clav | output | 1 | An untouched complete cell is waiting |
| ovf_pulse | output | 1 | One-cycle flag: an incoming cell was discarded |

## Verification
Two events can land on the same clock edge and both change the held-cell count: an incoming cell is completed while the reader takes the final byte of the other slot. The bench sets this up on purpose. It stores one cell, then starts writing a second cell and reading the first on the same cycle, so both finish on the same edge. Afterwards it expects `rd_clav` high with one cell held. A third cell must then be accepted without `ovf_pulse`, and the bytes of both remaining cells must read back in order.

// File: rtl/cell_rx_pkg.sv
`timescale 1ns/1ps
package cell_rx_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CELL_BYTES = 53;
  localparam int unsigned SLOTS      = 2;
  localparam int unsigned OFF_W      = $clog2(CELL_BYTES);
  localparam int unsigned SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CNT_W      = $clog2(SLOTS + 1);

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_KEEP = 2'd1,
    WR_DROP = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/cell_rx_writer.sv
`timescale 1ns/1ps
module cell_rx_writer
  import cell_rx_pkg::*;
#(
  parameter int unsigned CELLS = SLOTS,
  parameter int unsigned CLEN  = CELL_BYTES,
  localparam int unsigned OW   = $clog2(CLEN),
  localparam int unsigned SW   = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int unsigned CW   = $clog2(CELLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] cells_held,
  output logic          wr_we,
  output logic [SW-1:0] wr_slot,
  output logic [OW-1:0] wr_off,
  output logic          wr_commit,
  output logic          wr_reject
);
  wr_mode_e      mode_q, mode_d;
  logic [OW-1:0] off_q, off_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          room, at_end;

  assign room   = cells_held < CW'(CELLS);
  assign at_end = off_q == OW'(CLEN - 1);

  always_comb begin
    mode_d    = mode_q;
    off_d     = off_q;
    slot_d    = slot_q;
    wr_we     = 1'b0;
    wr_commit = 1'b0;
    wr_reject = 1'b0;
    if (in_valid) begin
      unique case (mode_q)
        WR_IDLE: begin
          off_d = OW'(1);
          if (room) begin
            mode_d = WR_KEEP;
            wr_we  = 1'b1;
          end else begin
            mode_d    = WR_DROP;
            wr_reject = 1'b1;
          end
        end
        WR_KEEP: begin
          wr_we = 1'b1;
          if (at_end) begin
            mode_d    = WR_IDLE;
            off_d     = '0;
            wr_commit = 1'b1;
            slot_d    = (slot_q == SW'(CELLS - 1)) ? '0 : slot_q + SW'(1);
          end else begin
            off_d = off_q + OW'(1);
          end
        end
        default: begin
          if (at_end) begin
            mode_d = WR_IDLE;
            off_d  = '0;
          end else begin
            off_d = off_q + OW'(1);
          end
        end
      endcase
    end
  end

  assign wr_slot = slot_q;
  assign wr_off  = off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WR_IDLE;
      off_q  <= '0;
      slot_q <= '0;
    end else if (in_valid) begin
      mode_q <= mode_d;
      off_q  <= off_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/cell_rx_reader.sv
`timescale 1ns/1ps
module cell_rx_reader
  import cell_rx_pkg::*;
#(
  parameter int unsigned CELLS = SLOTS,
  parameter int unsigned CLEN  = CELL_BYTES,
  localparam int unsigned OW   = $clog2(CLEN),
  localparam int unsigned SW   = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int unsigned CW   = $clog2(CELLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [CW-1:0] cells_held,
  output logic [SW-1:0] rd_slot,
  output logic [OW-1:0] rd_off,
  output logic          rd_fire,
  output logic          rd_done
);
  logic [OW-1:0] off_q, off_d;
  logic [SW-1:0] slot_q, slot_d;

  assign rd_fire = rd_en && (cells_held != '0);
  assign rd_done = rd_fire && (off_q == OW'(CLEN - 1));

  always_comb begin
    off_d  = off_q + OW'(1);
    slot_d = slot_q;
    if (rd_done) begin
      off_d  = '0;
      slot_d = (slot_q == SW'(CELLS - 1)) ? '0 : slot_q + SW'(1);
    end
  end

  assign rd_slot = slot_q;
  assign rd_off  = off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      slot_q <= '0;
    end else if (rd_fire) begin
      off_q  <= off_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/cell_rx_store.sv
`timescale 1ns/1ps
module cell_rx_store
  import cell_rx_pkg::*;
#(
  parameter int unsigned CELLS = SLOTS,
  parameter int unsigned CLEN  = CELL_BYTES,
  parameter int unsigned DW    = BYTE_W,
  localparam int unsigned OW   = $clog2(CLEN),
  localparam int unsigned SW   = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] w_slot,
  input  logic [OW-1:0] w_off,
  input  logic [DW-1:0] w_byte,
  input  logic [SW-1:0] r_slot,
  input  logic [OW-1:0] r_off,
  output logic [DW-1:0] r_byte
);
  logic [DW-1:0] slot_out [CELLS];

  for (genvar g = 0; g < CELLS; g++) begin : g_slot
    logic [DW-1:0] mem [CLEN];
    logic          sel_w;
    assign sel_w = we && (w_slot == SW'(g));
    always_ff @(posedge clk) begin
      if (sel_w) mem[w_off] <= w_byte;
    end
    assign slot_out[g] = mem[r_off];
  end

  always_comb begin
    r_byte = '0;
    for (int s = 0; s < CELLS; s++) begin
      if (r_slot == SW'(s)) r_byte = slot_out[s];
    end
  end
endmodule

// File: rtl/cell_rx_port.sv
`timescale 1ns/1ps
module cell_rx_port
  import cell_rx_pkg::*;
#(
  parameter int unsigned CELLS = SLOTS,
  parameter int unsigned CLEN  = CELL_BYTES,
  parameter int unsigned DW    = BYTE_W,
  localparam int unsigned OW   = $clog2(CLEN),
  localparam int unsigned SW   = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int unsigned CW   = $clog2(CELLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_soc,
  output logic          rd_empty,
  output logic          rd_clav,
  output logic          ovf_pulse
);
  logic          rs_meta, rs_n;
  logic [CW-1:0] held_q, held_d;
  logic          we, commit, reject, fire, done;
  logic [SW-1:0] w_slot, r_slot;
  logic [OW-1:0] w_off, r_off;
  logic          ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  cell_rx_writer #(.CELLS(CELLS), .CLEN(CLEN)) u_wr (
    .clk(clk), .rst_n(rs_n), .in_valid(in_valid), .cells_held(held_q),
    .wr_we(we), .wr_slot(w_slot), .wr_off(w_off),
    .wr_commit(commit), .wr_reject(reject)
  );

  cell_rx_reader #(.CELLS(CELLS), .CLEN(CLEN)) u_rd (
    .clk(clk), .rst_n(rs_n), .rd_en(rd_en), .cells_held(held_q),
    .rd_slot(r_slot), .rd_off(r_off), .rd_fire(fire), .rd_done(done)
  );

  cell_rx_store #(.CELLS(CELLS), .CLEN(CLEN), .DW(DW)) u_st (
    .clk(clk), .we(we), .w_slot(w_slot), .w_off(w_off), .w_byte(in_byte),
    .r_slot(r_slot), .r_off(r_off), .r_byte(rd_data)
  );

  always_comb begin
    unique case ({commit, done})
      2'b10:   held_d = held_q + CW'(1);
      2'b01:   held_d = held_q - CW'(1);
      default: held_d = held_q;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      held_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      ovf_q  <= reject;
    end
  end

  assign rd_empty  = held_q == '0;
  assign rd_soc    = !rd_empty && (r_off == '0);
  assign rd_clav   = (held_q >= CW'(2)) || (!rd_empty && (r_off == '0));
  assign ovf_pulse = ovf_q;
endmodule

// File: rtl/cell_rx_port_chk.sv
`timescale 1ns/1ps
module cell_rx_port_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_soc,
  input logic          rd_empty,
  input logic          rd_clav,
  input logic          ovf_pulse
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !in_valid) |=> ($stable(rd_data) && $stable(rd_soc) && $stable(rd_empty))); // R1
  AST_NEW_DATA_AT_SOC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_empty) |-> rd_soc); // R2
  AST_SOC_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_soc |-> !rd_empty); // R2
  AST_CLAV_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clav |-> !rd_empty); // R4
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R6
endmodule

bind cell_rx_port cell_rx_port_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_cell_rx_port.sv
`timescale 1ns/1ps
module sim_cell_rx_port;
  localparam int CLEN = 53;

  logic       clk, rst_n, in_valid, rd_en;
  logic [7:0] in_byte, rd_data;
  logic       rd_soc, rd_empty, rd_clav, ovf_pulse;

  int checks = 0;
  int fails  = 0;
  int rd_pos = 0;
  int ovf_seen = 0;

  typedef struct packed {
    logic       is_rd;
    logic [7:0] seed;
    logic [7:0] nbytes;
    logic       e_empty;
    logic       e_clav;
    logic       e_ovf;
  } vec_t;

  localparam vec_t VECS [8] = '{
    vec_t'({1'b0, 8'd10, 8'd53, 1'b0, 1'b1, 1'b0}),
    vec_t'({1'b0, 8'd40, 8'd53, 1'b0, 1'b1, 1'b0}),
    vec_t'({1'b0, 8'd70, 8'd53, 1'b0, 1'b1, 1'b1}),
    vec_t'({1'b1, 8'd10, 8'd53, 1'b0, 1'b1, 1'b0}),
    vec_t'({1'b1, 8'd40, 8'd20, 1'b0, 1'b0, 1'b0}),
    vec_t'({1'b0, 8'd90, 8'd53, 1'b0, 1'b1, 1'b0}),
    vec_t'({1'b1, 8'd40, 8'd33, 1'b0, 1'b1, 1'b0}),
    vec_t'({1'b1, 8'd90, 8'd53, 1'b1, 1'b0, 1'b0})
  };

  cell_rx_port u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .rd_en(rd_en), .rd_data(rd_data), .rd_soc(rd_soc), .rd_empty(rd_empty),
    .rd_clav(rd_clav), .ovf_pulse(ovf_pulse)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_bytes(input logic [7:0] seed, input int first, input int cnt);
    ovf_seen = 0;
    for (int i = 0; i < cnt; i++) begin
      in_valid = 1'b1;
      in_byte  = seed + 8'(first + i);
      @(posedge clk);
      @(negedge clk);
      if (ovf_pulse) ovf_seen++;
    end
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (ovf_pulse) ovf_seen++;
  endtask

  task automatic read_bytes(input logic [7:0] seed, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      chk("R3", "empty while reading", int'(rd_empty), 0);
      chk("R2", "soc", int'(rd_soc), (rd_pos == 0) ? 1 : 0);
      chk("R5", "data", int'(rd_data), int'(8'(seed + 8'(rd_pos))));
      rd_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      rd_pos = (rd_pos + 1) % CLEN;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    rd_en = 1'b0;
    in_byte = '0;
    @(negedge clk);
    chk("R9", "empty in reset", int'(rd_empty), 1);
    chk("R9", "clav in reset", int'(rd_clav), 0);
    chk("R9", "soc in reset", int'(rd_soc), 0);
    chk("R9", "ovf in reset", int'(ovf_pulse), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_pos = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    rd_en = 1'b0;
    in_byte = '0;
    do_reset();
    chk("R9", "empty after reset", int'(rd_empty), 1);
    chk("R9", "clav after reset", int'(rd_clav), 0);

    // table walk: R4, R5, R6
    for (int v = 0; v < 8; v++) begin
      if (VECS[v].is_rd) begin
        read_bytes(VECS[v].seed, int'(VECS[v].nbytes));
      end else begin
        write_bytes(VECS[v].seed, 0, int'(VECS[v].nbytes));
        chk("R6", "overflow pulse cycles", ovf_seen, VECS[v].e_ovf ? 1 : 0);
      end
      chk("R3", "empty after vector", int'(rd_empty), int'(VECS[v].e_empty));
      chk("R4", "clav after vector", int'(rd_clav), int'(VECS[v].e_clav));
    end

    // R7: reads while empty are ignored
    rd_en = 1'b1;
    repeat (4) @(negedge clk);
    rd_en = 1'b0;
    chk("R7", "empty after idle reads", int'(rd_empty), 1);
    write_bytes(8'd200, 0, CLEN);
    chk("R7", "soc at first byte", int'(rd_soc), 1);
    chk("R7", "first byte", int'(rd_data), 200);
    read_bytes(8'd200, CLEN);
    chk("R3", "empty after drain", int'(rd_empty), 1);

    // R3, R4: partly written cell is invisible
    write_bytes(8'd120, 0, 30);
    chk("R3", "empty with partial cell", int'(rd_empty), 1);
    chk("R4", "clav with partial cell", int'(rd_clav), 0);
    rd_en = 1'b1;
    repeat (2) @(negedge clk);
    rd_en = 1'b0;
    write_bytes(8'd120, 30, CLEN - 30);
    chk("R4", "clav after completion", int'(rd_clav), 1);
    chk("R7", "soc kept after ignored reads", int'(rd_soc), 1);
    chk("R7", "byte 0 kept after ignored reads", int'(rd_data), 120);

    // R8: commit and final read on the same edge
    fork
      write_bytes(8'd150, 0, CLEN);
      read_bytes(8'd120, CLEN);
    join
    chk("R8", "empty after same-edge events", int'(rd_empty), 0);
    chk("R8", "clav after same-edge events", int'(rd_clav), 1);
    write_bytes(8'd180, 0, CLEN);
    chk("R8", "third cell accepted", ovf_seen, 0);
    read_bytes(8'd150, CLEN);
    read_bytes(8'd180, CLEN);
    chk("R8", "empty after both cells", int'(rd_empty), 1);

    // R9: reset discards a held cell
    write_bytes(8'd33, 0, CLEN);
    chk("R9", "cell held before reset", int'(rd_empty), 0);
    do_reset();
    chk("R9", "cell lost after reset", int'(rd_empty), 1);
    chk("R9", "clav after reset", int'(rd_clav), 0);

    report();
    $finish;
  end
endmodule